// File: doc/BRIEF.md
# Bit-Serial Adder with Registered Sum Output

This block adds two unsigned operands of `WIDTH` bits by working through them one bit position per clock, starting at the least significant bit. A reset pulse copies both operands into internal shift registers, which move toward bit 0 on each following cycle. A four-state controller holds the running carry and the sum bit of the latest position. Because the sum leaves the controller from a register, no path runs from the operand bits to the result through logic alone.

The registered sum bit trails the operand bits by one cycle. The capture stage therefore lets the first cycle after reset pass, then shifts exactly `WIDTH` sum bits into the result register, entering at the top end. When the last bit is in, the block raises `done` and freezes the result until the next reset. The carry out of the top position is dropped, so the result is the sum modulo 2^WIDTH.

To use it, hold `rst` high for at least one rising edge with the operands on `opnd_a` and `opnd_b`. Release `rst` and read `sum_out` once `done` is high.

Top module: `serial_add_moore`

## Requirements
- R1: A rising edge with `rst` high loads both operands, puts the controller in its carry-0/sum-0 state and drives `done` low on the next cycle.
- R2: On each cycle after reset release, the controller's next carry is the majority of the two operand low bits and the present carry (full-adder carry).
- R3: The serial sum bit is a state bit: after each edge it equals the XOR of the operand low bits and carry sampled at that edge, and it has no combinational dependence on the operand inputs.
- R4: The operand registers shift toward bit 0 with 0 filling the top bit, so bit position k is added on the k-th cycle after reset release (counting from 0).
- R5: `done` rises exactly after the (WIDTH+1)-th rising edge following reset release and stays low before it.
- R6: While `done` is high and `rst` is low, `done` stays high and `sum_out` holds its value, even if `opnd_a` and `opnd_b` change.
- R7: When `done` is high, `sum_out` equals (opnd_a + opnd_b) mod 2^WIDTH for the operands present at the last reset edge, with sum bit 0 in `sum_out[0]`.
- R8: The carry out of bit WIDTH-1 is discarded (for example, all ones plus one gives zero).
- R9: Asserting `rst` during an addition abandons it and restarts with the operands present at that reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads operands and restarts |
| opnd_a | input | WIDTH | First operand, sampled when `rst` is high |
| opnd_b | input | WIDTH | Second operand, sampled when `rst` is high |
| sum_out | output | WIDTH | Collected sum, valid while `done` is high |
| done | output | 1 | High once all WIDTH sum bits are captured |

## Verification
The assertions assume that `rst` is held high across at least one rising edge before any operation starts. They also assume that the operand inputs matter only at reset edges, so nothing is assumed about them between resets. The stimulus starts every addition with a one-cycle reset pulse driven at the falling edge. Between resets it changes the operand inputs freely to show that they are ignored, and it restarts one addition partway through.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

    // Controller state: upper bit is the carry, lower bit is the sum bit on show.
    typedef enum logic [1:0] {
        ST_C0_S0 = 2'b00,
        ST_C0_S1 = 2'b01,
        ST_C1_S0 = 2'b10,
        ST_C1_S1 = 2'b11
    } ctl_state_e;

    // Capture stage register set.
    function automatic int unsigned cnt_bits(input int unsigned width);
        return $clog2(width + 2);
    endfunction

endpackage

// File: rtl/serial_add_opnd_shift.sv
module serial_add_opnd_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             load,
    input  logic [WIDTH-1:0] par_in,
    output logic             low_bit
);

    logic [WIDTH-1:0] shreg_d;
    logic [WIDTH-1:0] shreg_q;

    always_comb begin
        if (load) begin
            shreg_d = par_in;
        end else begin
            shreg_d = {1'b0, shreg_q[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        shreg_q <= shreg_d;
    end

    assign low_bit = shreg_q[0];

endmodule

// File: rtl/serial_add_ctl.sv
module serial_add_ctl
    import serial_add_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_a,
    input  logic bit_b,
    output logic carry,
    output logic sum_bit
);

    ctl_state_e state_d;
    ctl_state_e state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_C0_S0, ST_C0_S1: begin
                unique case ({bit_a, bit_b})
                    2'b00:   state_d = ST_C0_S0;
                    2'b01:   state_d = ST_C0_S1;
                    2'b10:   state_d = ST_C0_S1;
                    default: state_d = ST_C1_S0;
                endcase
            end
            default: begin
                unique case ({bit_a, bit_b})
                    2'b00:   state_d = ST_C0_S1;
                    2'b01:   state_d = ST_C1_S0;
                    2'b10:   state_d = ST_C1_S0;
                    default: state_d = ST_C1_S1;
                endcase
            end
        endcase
        if (rst) begin
            state_d = ST_C0_S0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign carry   = state_q[1];
    assign sum_bit = state_q[0];

endmodule

// File: rtl/serial_add_capture.sv
module serial_add_capture
    import serial_add_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sum_bit,
    output logic [WIDTH-1:0] result,
    output logic             done
);

    localparam int CW = cnt_bits(WIDTH);
    localparam logic [CW-1:0] CNT_LOAD = CW'(WIDTH + 1);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [WIDTH-1:0] res;
    } cap_regs_t;

    cap_regs_t cap_d;
    cap_regs_t cap_q;

    logic running;
    logic capture;

    always_comb begin
        running = (cap_q.cnt != '0);
        // The first running cycle only lets the registered sum catch up.
        capture = running && (cap_q.cnt != CNT_LOAD);
        cap_d   = cap_q;
        if (running) begin
            cap_d.cnt = cap_q.cnt - 1'b1;
        end
        if (capture) begin
            cap_d.res = {sum_bit, cap_q.res[WIDTH-1:1]};
        end
        if (rst) begin
            cap_d.cnt = CNT_LOAD;
            cap_d.res = '0;
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    assign result = cap_q.res;
    assign done   = !running;

endmodule

// File: rtl/serial_add_moore.sv
module serial_add_moore #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] sum_out,
    output logic             done
);

    localparam int NUM_OPND = 2;

    logic [WIDTH-1:0] opnd_bus [NUM_OPND];
    logic [NUM_OPND-1:0] low_bits;
    logic lsb_a;
    logic lsb_b;
    logic carry_q;
    logic sum_bit_q;

    assign opnd_bus[0] = opnd_a;
    assign opnd_bus[1] = opnd_b;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        serial_add_opnd_shift #(.WIDTH(WIDTH)) u_shift (
            .clk     (clk),
            .load    (rst),
            .par_in  (opnd_bus[g]),
            .low_bit (low_bits[g])
        );
    end

    assign lsb_a = low_bits[0];
    assign lsb_b = low_bits[1];

    serial_add_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .bit_a   (lsb_a),
        .bit_b   (lsb_b),
        .carry   (carry_q),
        .sum_bit (sum_bit_q)
    );

    serial_add_capture #(.WIDTH(WIDTH)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .sum_bit (sum_bit_q),
        .result  (sum_out),
        .done    (done)
    );

endmodule

// File: rtl/serial_add_chk.sv
module serial_add_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             lsb_a,
    input logic             lsb_b,
    input logic             carry,
    input logic             sum_bit,
    input logic             done,
    input logic [WIDTH-1:0] sum_out
);

    localparam int CCW = $clog2(WIDTH + 3);
    localparam logic [CCW-1:0] CYC_MAX  = CCW'(WIDTH + 2);
    localparam logic [CCW-1:0] CYC_DONE = CCW'(WIDTH + 1);

    logic [CCW-1:0] cyc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
        end else if (cyc_q != CYC_MAX) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!done && !carry && !sum_bit));

    a_r2_carry_update: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (carry == (($past(lsb_a) & $past(lsb_b)) |
                            ($past(lsb_a) & $past(carry)) |
                            ($past(lsb_b) & $past(carry)))));

    a_r3_sum_registered: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sum_bit == ($past(lsb_a) ^ $past(lsb_b) ^ $past(carry))));

    a_r5_done_timing: assert property (@(posedge clk) disable iff (rst)
        done == (cyc_q >= CYC_DONE));

    a_r6_done_holds: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    a_r6_result_frozen: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(sum_out));

endmodule

bind serial_add_moore serial_add_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .lsb_a   (lsb_a),
    .lsb_b   (lsb_b),
    .carry   (carry_q),
    .sum_bit (sum_bit_q),
    .done    (done),
    .sum_out (sum_out)
);

// File: tb/tb_serial_add_moore.sv
module tb_serial_add_moore;

    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG_CYCLES = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] sum_out;
    logic         done;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    serial_add_moore #(.WIDTH(W)) dut (
        .clk     (clk),
        .rst     (rst),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .sum_out (sum_out),
        .done    (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG_CYCLES) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    function automatic logic [W-1:0] model_sum(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] full;
        full = {1'b0, a} + {1'b0, b};
        return full[W-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Full addition: reset pulse, WIDTH+1 running edges, then result and hold checks.
    task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        logic [W-1:0] exp;
        logic [W-1:0] held;
        exp = model_sum(a, b);
        @(negedge clk);
        rst = 1'b1;
        opnd_a = a;
        opnd_b = b;
        @(negedge clk);
        check(done == 1'b0, "R1 done low after reset", W'(done), '0);
        rst = 1'b0;
        opnd_a = ~a;
        opnd_b = b ^ 8'h5A;
        for (int i = 0; i <= W; i++) begin
            @(negedge clk);
            if (i < W) begin
                if (done) check(1'b0, "R5 done early", W'(i), W'(W));
            end else begin
                check(done == 1'b1, "R5 done after WIDTH+1 edges", W'(done), W'(1));
                check(sum_out == exp, {"R7 sum ", req}, sum_out, exp);
            end
        end
        held = sum_out;
        opnd_a = $urandom();
        opnd_b = $urandom();
        repeat (3) @(negedge clk);
        check(done == 1'b1 && sum_out == held, "R6 result frozen while done", sum_out, held);
    endtask

    initial begin
        void'($urandom(32'h0BADCAFE));
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(done == 1'b0, "R1 reset state", W'(done), '0);

        run_add('0, '0, "R7 zero plus zero");
        run_add('1, W'(1), "R8 all ones plus one wraps");
        check(sum_out == '0, "R8 carry out dropped", sum_out, '0);
        run_add('1, '1, "R2 carry chain all ones");
        run_add(8'hAA, 8'h55, "R4 alternating no carry");
        run_add(8'h55, 8'h55, "R2 alternating carries");
        run_add(8'h80, 8'h80, "R8 top bit carry");
        run_add(8'h01, 8'h00, "R4 bit0 lands in sum_out[0]");
        run_add(8'h00, 8'h80, "R3 top bit only");

        // R9: restart partway through an addition.
        @(negedge clk);
        rst = 1'b1;
        opnd_a = 8'hF0;
        opnd_b = 8'h0F;
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        run_add(8'h3C, 8'h99, "R9 restart mid operation");

        for (int k = 0; k < 40; k++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = W'($urandom());
            rb = W'($urandom());
            if (k % 5 == 0) rb = ~ra;
            run_add(ra, rb, "R7 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule